// File: doc/BRIEF.md
# Dual-Loop Synthesizer Divider and Phase Comparator

This block is the digital heart of a frequency synthesizer that runs a receive loop and a transmit loop from one crystal. Every rising edge of `clk` is one crystal period. A programmable reference divider turns the crystal into a comparison pulse. Each loop has its own 14-bit feedback divider. That divider counts single-cycle edge strobes taken from the loop's VCO after the input buffer. The strobes must already be synchronous to `clk`.

A small routing stage can slow the comparison pulse further, by 4 or by 25, on a per-loop basis. A two-bit select chooses the route for both loops from a fixed table. Each loop then feeds a three-state phase-frequency comparator. The comparator drives pump-up and pump-down pulses and an enable for the external charge pump. When the enable is low, the pump pin floats.

A lock monitor watches the pulse widths of both comparators and drives one active-high unlock flag. All ratios and the route select are plain parallel inputs from a register file elsewhere. Typical settings are a reference ratio of 2048, a receive ratio of 7215 and a transmit ratio of 9966. There are no data streams, so there is no valid/ready handshake: all pins are level control or status signals.

Top module: `dual_pll_core`

## Requirements
- R1: While `rst_n` is low and just after it is released, `rx_up`, `rx_dn`, `tx_up`, `tx_dn`, `rx_oe` and `tx_oe` are 0 and `unlock` is 1.
- R2: The reference divider emits one pulse every `ref_ratio` clock cycles. A `ref_ratio` below 16 behaves as 16. The first pulse follows the first clock after reset.
- R3: Each feedback divider emits one pulse per `*_ratio` strobes on its tick input. A ratio below 16 behaves as 16. The first pulse follows the first strobe after reset.
- R4: When a loop's feedback pulse arrives later than its comparison pulse, `*_up` goes high for exactly as many cycles as the lag, and `*_dn` stays low.
- R5: When a loop's feedback pulse arrives earlier than its comparison pulse, `*_dn` goes high for exactly as many cycles as the lead, and `*_up` stays low.
- R6: When a comparison pulse and a feedback pulse arrive in the same cycle, neither pump output rises.
- R7: `*_oe` is 1 exactly while that loop's `*_up` or `*_dn` is 1, so the pump floats when the loop is in phase.
- R8: `route_sel` picks the comparison source for each loop. 00 gives direct/direct. 01 gives TX direct and RX /4. 10 gives TX /4 and RX /25. 11 gives /25 for both. The divided paths add one cycle of delay.
- R9: A loop is locked after 4 consecutive comparison periods in which no pump pulse lasted longer than 1 cycle. `unlock` is 0 only while both loops are locked.
- R10: A comparison period that contains a pump pulse of 2 or more cycles clears that loop's lock count, so `unlock` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | crystal clock |
| rst_n | input | 1 | active-low synchronous reset |
| ref_ratio | input | 12 | reference divide ratio |
| rx_ratio | input | 14 | receive feedback ratio |
| tx_ratio | input | 14 | transmit feedback ratio |
| route_sel | input | 2 | comparison source select |
| rx_fb_tick | input | 1 | receive VCO edge strobe |
| tx_fb_tick | input | 1 | transmit VCO edge strobe |
| rx_up | output | 1 | receive pump-up pulse |
| rx_dn | output | 1 | receive pump-down pulse |
| rx_oe | output | 1 | receive pump drive enable |
| tx_up | output | 1 | transmit pump-up pulse |
| tx_dn | output | 1 | transmit pump-down pulse |
| tx_oe | output | 1 | transmit pump drive enable |
| unlock | output | 1 | 1 while either loop is unlocked |

## Verification
Latency is counted from the clock edge that sees the last enable, strobe or reference pulse of a period:

- Each divider pulse is registered and appears one cycle after that edge.
- A comparator sees that pulse at the following edge, so pump widths equal the arrival skew of the two divider pulses.
- A routed /4 or /25 path adds one extra cycle, which the lock window of 1 cycle tolerates.
- `unlock` changes at the edge that takes in the fourth good comparison.

The bench samples only on falling edges. It measures pump pulses as run lengths over fixed windows. It reads `unlock` at cycle counts chosen with margin either side of the computed comparison edges.

// File: rtl/pll_pkg.sv
package pll_pkg;
  localparam int REF_W     = 12;
  localparam int FB_W      = 14;
  localparam int MIN_RATIO = 16;
  localparam int LOCK_TOL  = 1;
  localparam int LOCK_CNT  = 4;
  localparam int N_LOOPS   = 2;
  localparam int LOOP_RX   = 0;
  localparam int LOOP_TX   = 1;

  typedef enum logic [1:0] {RT_DIRECT = 2'd0, RT_QUARTER = 2'd1, RT_TWENTYFIFTH = 2'd2} route_t;

  function automatic route_t route_pick(input logic [1:0] sel, input int loop);
    route_t r;
    case (sel)
      2'b00:   r = RT_DIRECT;
      2'b01:   r = (loop == LOOP_TX) ? RT_DIRECT : RT_QUARTER;
      2'b10:   r = (loop == LOOP_TX) ? RT_QUARTER : RT_TWENTYFIFTH;
      default: r = RT_TWENTYFIFTH;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pll_divider.sv
module pll_divider #(
  parameter int W   = 14,
  parameter int MIN = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] ratio,
  output logic         tc
);
  logic [W-1:0] cnt;
  logic [W-1:0] eff;

  assign eff = (ratio < W'(MIN)) ? W'(MIN) : ratio;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= W'(1);
      tc  <= 1'b0;
    end else begin
      tc <= 1'b0;
      if (en) begin
        if (cnt <= W'(1)) begin
          cnt <= eff;
          tc  <= 1'b1;
        end else begin
          cnt <= cnt - W'(1);
        end
      end
    end
  end

  // R2 R3
  div_no_double_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> !tc);
endmodule

// File: rtl/pll_route.sv
module pll_route
  import pll_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_p,
  input  logic [1:0]         sel,
  output logic [N_LOOPS-1:0] cmp_p
);
  logic p4, p25;

  pll_divider #(.W(3), .MIN(2)) u_quarter (
    .clk(clk), .rst_n(rst_n), .en(ref_p), .ratio(3'd4), .tc(p4));
  pll_divider #(.W(5), .MIN(2)) u_twentyfifth (
    .clk(clk), .rst_n(rst_n), .en(ref_p), .ratio(5'd25), .tc(p25));

  for (genvar g = 0; g < N_LOOPS; g++) begin : g_mux
    always_comb begin
      case (route_pick(sel, g))
        RT_QUARTER:     cmp_p[g] = p4;
        RT_TWENTYFIFTH: cmp_p[g] = p25;
        default:        cmp_p[g] = ref_p;
      endcase
    end
  end

  // R8
  route_quarter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p4 |-> $past(ref_p));
endmodule

// File: rtl/pll_pfd.sv
module pll_pfd
  import pll_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ref_p,
  input  logic fb_p,
  output logic up_q,
  output logic dn_q,
  output logic locked
);
  localparam int GW = $clog2(LOCK_CNT + 1);

  logic          up_n, dn_n, active, bad_now, bad_win;
  logic [7:0]    wcnt;
  logic [GW-1:0] good;

  assign up_n    = up_q | ref_p;
  assign dn_n    = dn_q | fb_p;
  assign active  = up_q | dn_q;
  assign bad_now = active && (wcnt >= 8'(LOCK_TOL));
  assign locked  = (good == GW'(LOCK_CNT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (up_n && dn_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_n;
      dn_q <= dn_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt    <= '0;
      bad_win <= 1'b0;
      good    <= '0;
    end else begin
      if (active) wcnt <= (wcnt == 8'hFF) ? wcnt : wcnt + 8'd1;
      else        wcnt <= '0;
      if (ref_p) begin
        bad_win <= 1'b0;
        if (bad_win || bad_now)       good <= '0;
        else if (good < GW'(LOCK_CNT)) good <= good + GW'(1);
      end else begin
        bad_win <= bad_win | bad_now;
      end
    end
  end

  // R4
  pfd_up_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_q) |-> ($past(ref_p) && !$past(fb_p)));
  // R5
  pfd_dn_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_q) |-> ($past(fb_p) && !$past(ref_p)));
  // R6
  pfd_coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_p && fb_p && !up_q && !dn_q) |=> (!up_q && !dn_q));
  // R9
  lock_at_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(ref_p));
endmodule

// File: rtl/dual_pll_core.sv
module dual_pll_core
  import pll_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REF_W-1:0] ref_ratio,
  input  logic [FB_W-1:0]  rx_ratio,
  input  logic [FB_W-1:0]  tx_ratio,
  input  logic [1:0]       route_sel,
  input  logic             rx_fb_tick,
  input  logic             tx_fb_tick,
  output logic             rx_up,
  output logic             rx_dn,
  output logic             rx_oe,
  output logic             tx_up,
  output logic             tx_dn,
  output logic             tx_oe,
  output logic             unlock
);
  logic               ref_p;
  logic [N_LOOPS-1:0] cmp_p, fb_p, tick, up, dn, locked;
  logic [FB_W-1:0]    ratio [N_LOOPS];

  assign tick[LOOP_RX]  = rx_fb_tick;
  assign tick[LOOP_TX]  = tx_fb_tick;
  assign ratio[LOOP_RX] = rx_ratio;
  assign ratio[LOOP_TX] = tx_ratio;

  pll_divider #(.W(REF_W), .MIN(MIN_RATIO)) u_ref_div (
    .clk(clk), .rst_n(rst_n), .en(1'b1), .ratio(ref_ratio), .tc(ref_p));

  pll_route u_route (
    .clk(clk), .rst_n(rst_n), .ref_p(ref_p), .sel(route_sel), .cmp_p(cmp_p));

  for (genvar g = 0; g < N_LOOPS; g++) begin : g_loop
    pll_divider #(.W(FB_W), .MIN(MIN_RATIO)) u_fb_div (
      .clk(clk), .rst_n(rst_n), .en(tick[g]), .ratio(ratio[g]), .tc(fb_p[g]));
    pll_pfd u_pfd (
      .clk(clk), .rst_n(rst_n), .ref_p(cmp_p[g]), .fb_p(fb_p[g]),
      .up_q(up[g]), .dn_q(dn[g]), .locked(locked[g]));
  end

  assign rx_up  = up[LOOP_RX];
  assign rx_dn  = dn[LOOP_RX];
  assign tx_up  = up[LOOP_TX];
  assign tx_dn  = dn[LOOP_TX];
  assign rx_oe  = up[LOOP_RX] | dn[LOOP_RX];
  assign tx_oe  = up[LOOP_TX] | dn[LOOP_TX];
  assign unlock = ~&locked;

  // R1
  reset_unlock_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> unlock);
endmodule

// File: tb/dual_pll_core_bench.sv
module dual_pll_core_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [11:0] ref_ratio = 12'd16;
  logic [13:0] rx_ratio = 14'd16, tx_ratio = 14'd16;
  logic [1:0]  route_sel = 2'b00;
  logic        rx_fb_tick = 1'b1, tx_fb_tick = 1'b1;
  logic        rx_up, rx_dn, rx_oe, tx_up, tx_dn, tx_oe, unlock;
  int          n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  dual_pll_core u_dual_pll_core (
    .clk(clk), .rst_n(rst_n), .ref_ratio(ref_ratio), .rx_ratio(rx_ratio),
    .tx_ratio(tx_ratio), .route_sel(route_sel), .rx_fb_tick(rx_fb_tick),
    .tx_fb_tick(tx_fb_tick), .rx_up(rx_up), .rx_dn(rx_dn), .rx_oe(rx_oe),
    .tx_up(tx_up), .tx_dn(tx_dn), .tx_oe(tx_oe), .unlock(unlock));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start(input int rr, input int rxr, input int txr, input logic [1:0] s);
    @(negedge clk);
    rst_n = 1'b0; ref_ratio = 12'(rr); rx_ratio = 14'(rxr); tx_ratio = 14'(txr);
    route_sel = s; rx_fb_tick = 1'b1; tx_fb_tick = 1'b1;
    repeat (3) @(negedge clk);
    check(!rx_up && !rx_dn && !rx_oe && !tx_up && !tx_dn && !tx_oe, "R1 pumps in reset", 1, 0);
    check(unlock == 1'b1, "R1 unlock in reset", int'(unlock), 1);
    rst_n = 1'b1;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // feedback leads (ref 20, fb 16): dn runs of 4 then 8 on rx
  task automatic t_lead();
    int runs[2]; int nr = 0, cur = 0, upc = 0, oebad = 0;
    start(20, 16, 20, 2'b00);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (rx_up) upc++;
      if (rx_oe != (rx_up | rx_dn)) oebad++;
      if (rx_dn) cur++;
      else if (cur != 0) begin if (nr < 2) runs[nr] = cur; nr++; cur = 0; end
    end
    check(nr >= 2 && runs[0] == 4, "R5 R2 first dn width", runs[0], 4);
    check(nr >= 2 && runs[1] == 8, "R5 second dn width", runs[1], 8);
    check(upc == 0, "R5 no up", upc, 0);
    check(oebad == 0, "R7 oe tracks pumps", oebad, 0);
  endtask

  // feedback lags (ref 16, fb 20): up runs of 4 then 8 on tx
  task automatic t_lag();
    int runs[2]; int nr = 0, cur = 0, dnc = 0, oebad = 0;
    start(16, 16, 20, 2'b00);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (tx_dn) dnc++;
      if (tx_oe != (tx_up | tx_dn)) oebad++;
      if (tx_up) cur++;
      else if (cur != 0) begin if (nr < 2) runs[nr] = cur; nr++; cur = 0; end
    end
    check(nr >= 2 && runs[0] == 4, "R4 first up width", runs[0], 4);
    check(nr >= 2 && runs[1] == 8, "R4 second up width", runs[1], 8);
    check(dnc == 0, "R4 no dn", dnc, 0);
    check(oebad == 0, "R7 oe tracks pumps", oebad, 0);
  endtask

  // aligned: no pump activity, lock after the fourth comparison, not before
  task automatic t_lock();
    int act = 0;
    start(100, 100, 100, 2'b00);
    for (int i = 0; i < 280; i++) begin
      @(negedge clk);
      if (rx_oe || tx_oe || rx_up || tx_dn) act++;
    end
    check(act == 0, "R6 coincident pulses idle", act, 0);
    check(unlock == 1'b1, "R9 still unlocked after 3 comparisons", int'(unlock), 1);
    wait_n(50);
    check(unlock == 1'b0, "R9 locked after 4 comparisons", int'(unlock), 0);
    tx_ratio = 14'd103;
    wait_n(400);
    check(unlock == 1'b1, "R10 lock lost on drift", int'(unlock), 1);
  endtask

  task automatic t_clamp();
    start(3, 16, 16, 2'b00);
    wait_n(120);
    check(unlock == 1'b0, "R2 reference ratio clamp", int'(unlock), 0);
    start(16, 5, 2, 2'b00);
    wait_n(120);
    check(unlock == 1'b0, "R3 feedback ratio clamp", int'(unlock), 0);
  endtask

  task automatic t_route();
    start(16, 400, 64, 2'b00);
    wait_n(2500);
    check(unlock == 1'b1, "R8 direct route misses divided loops", int'(unlock), 1);
    start(16, 400, 64, 2'b10);
    wait_n(2500);
    check(unlock == 1'b0, "R8 route 10 tx/4 rx/25", int'(unlock), 0);
    start(16, 64, 16, 2'b01);
    wait_n(600);
    check(unlock == 1'b0, "R8 route 01 tx direct rx/4", int'(unlock), 0);
    start(16, 400, 400, 2'b11);
    wait_n(2500);
    check(unlock == 1'b0, "R8 route 11 both /25", int'(unlock), 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_lead();
    t_lag();
    t_lock();
    t_clamp();
    t_route();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule